// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one unsigned N-bit operand by another. It finds one quotient bit per clock cycle with a trial subtraction and a restore. The partial remainder and the growing quotient share a single shift register. The upper part of that register holds the running remainder, and quotient bits enter at the bottom of the lower part. The loop takes exactly N steps. It starts after a single left shift, which is folded into the load. Because the operand register is reused for the quotient, the running remainder finishes one place too far left. One extra cycle shifts only the upper part back to the right.

A request is made by pulsing `start` while `busy` is low. The operands are captured on that edge, and `busy` then stays high for N+1 cycles. On the cycle after the last one, `done` is high for exactly one cycle. From then until the next accepted request, `quotient` and `remainder` hold the result. A zero divisor raises `divByZero`. It still completes with the same timing. The quotient comes out as all ones and the remainder equals the dividend.

Top module: `restoring_divider`

## Requirements
- R1: After reset, `busy`, `done` and `divByZero` are 0, and `quotient` and `remainder` read 0.
- R2: A `start` sampled high while `busy` is low captures `dividend` and `divisor`. `busy` is high from the next cycle through N+1 cycles.
- R3: If the accepted `start` is sampled at clock edge k, `done` is high for exactly one cycle, following edge k+N+1. `done` is never high while `busy` is high.
- R4: For a nonzero divisor, the result satisfies dividend = quotient × divisor + remainder with remainder < divisor. The running remainder never reaches twice the divisor.
- R5: While `busy` is low and `start` is low, `quotient` and `remainder` keep their values.
- R6: A `start` raised while `busy` is high is ignored. The running division completes with its original operands and timing.
- R7: A zero divisor sets `divByZero` and completes with `quotient` all ones and `remainder` equal to the dividend. The flag clears when a later request has a nonzero divisor.
- R8: Boundary operands give exact results. These are a divisor of 1, a dividend smaller than the divisor, a zero dividend, and operands at the maximum value 2^N−1, including a remainder at or above 2^(N−1).
- R9: A new request may be accepted in the same cycle that `done` is high. Back-to-back requests each produce their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| dividend | input | N | Unsigned dividend |
| divisor | input | N | Unsigned divisor |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| quotient | output | N | Unsigned quotient |
| remainder | output | N | Unsigned remainder |
| divByZero | output | 1 | Last accepted request had a zero divisor |

## Verification
The embedded properties check several things on every cycle. `done` is a single-cycle pulse and never overlaps `busy`. The running remainder stays below twice the captured divisor. The corrected remainder is below the divisor, and a zero divisor yields an all-ones quotient. Results also hold while the block is idle. The exact latency of each request, the identity dividend = quotient × divisor + remainder, and correct boundary results are shown only by the scenarios. The same holds for ignoring a start while busy and for clearing the zero-divisor flag on a later request.

// File: rtl/divu_pkg.sv
package divu_pkg;
  // Strobes from the sequencer to the datapath; at most one is high per cycle.
  typedef struct packed {
    logic load;  // capture operands, apply the initial left shift
    logic step;  // one trial subtract plus shift
    logic fix;   // move the upper half right by one
  } divStrobe_t;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl #(
  parameter int N = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  output divu_pkg::divStrobe_t strb,
  output logic                 busy,
  output logic                 done
);
  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} state_t;

  state_t        state;
  logic [CW-1:0] stepCount;

  always_comb begin
    strb      = '0;
    strb.load = (state == S_IDLE) && start;
    strb.step = (state == S_RUN);
    strb.fix  = (state == S_FIX);
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      stepCount <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          state     <= S_RUN;
          stepCount <= '0;
        end
        S_RUN: begin
          if (stepCount == LAST) state <= S_FIX;
          else                   stepCount <= stepCount + 1'b1;
        end
        S_FIX: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: done is a single-cycle pulse
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R3: done never overlaps busy
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R2: busy rises only because of a start request
  a_r2_busy_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/div_dpath.sv
module div_dpath #(
  parameter int N = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  divu_pkg::divStrobe_t strb,
  input  logic [N-1:0]         dividendIn,
  input  logic [N-1:0]         divisorIn,
  output logic [N-1:0]         quotient,
  output logic [N-1:0]         remainder,
  output logic                 divByZero
);
  localparam int UW = N + 1;  // upper half carries one guard bit
  localparam int TW = N + 2;  // trial difference keeps its sign bit

  logic [UW-1:0] upperQ;
  logic [N-1:0]  lowerQ;
  logic [N-1:0]  divisorQ;
  logic          zeroQ;

  logic [TW-1:0] trial;
  logic          fits;
  logic [UW-1:0] keptUpper;

  assign trial     = {1'b0, upperQ} - {2'b00, divisorQ};
  assign fits      = ~trial[TW-1];
  assign keptUpper = fits ? trial[UW-1:0] : upperQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperQ   <= '0;
      lowerQ   <= '0;
      divisorQ <= '0;
      zeroQ    <= 1'b0;
    end else if (strb.load) begin
      upperQ   <= {{N{1'b0}}, dividendIn[N-1]};
      lowerQ   <= {dividendIn[N-2:0], 1'b0};
      divisorQ <= divisorIn;
      zeroQ    <= (divisorIn == '0);
    end else if (strb.step) begin
      upperQ <= {keptUpper[N-1:0], lowerQ[N-1]};
      lowerQ <= {lowerQ[N-2:0], fits};
    end else if (strb.fix) begin
      upperQ <= upperQ >> 1;
    end
  end

  assign quotient  = lowerQ;
  assign remainder = upperQ[N-1:0];
  assign divByZero = zeroQ;

  // R4: running remainder stays below twice the divisor
  a_r4_partial_bound: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !zeroQ) |-> ({1'b0, upperQ} < {1'b0, divisorQ, 1'b0}));
  // R4: corrected remainder is below the divisor
  a_r4_rem_bound: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fix && !zeroQ) |=> (remainder < divisorQ));
  // R7: zero divisor yields an all-ones quotient
  a_r7_zero_quot: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fix && zeroQ) |=> (quotient == {N{1'b1}}));
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder,
  output logic         divByZero
);
  divu_pkg::divStrobe_t strb;

  div_ctrl #(.N(N)) ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .strb (strb),
    .busy (busy),
    .done (done)
  );

  div_dpath #(.N(N)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dividendIn(dividend),
    .divisorIn (divisor),
    .quotient  (quotient),
    .remainder (remainder),
    .divByZero (divByZero)
  );

  // R5: results hold while idle without a request
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));
endmodule

// File: tb/restoring_divider_tb_top.sv
`timescale 1ns/1ps
module restoring_divider_tb_top;
  localparam int N = 32;
  localparam logic [N-1:0] MAXV = {N{1'b1}};

  typedef struct {
    logic [N-1:0] dvd;
    logic [N-1:0] dvs;
    logic [N-1:0] expQ;
    logic [N-1:0] expR;
    logic         expZ;
    int           doneCyc;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] dividend = '0;
  logic [N-1:0] divisor = '0;
  logic busy, done, divByZero;
  logic [N-1:0] quotient, remainder;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  item_t sb[$];
  logic [N-1:0] lastQ, lastR;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  restoring_divider #(.N(N)) dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder),
    .divByZero(divByZero)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: wait for idle, issue a request, push the expected result.
  task automatic issue(input logic [N-1:0] a, input logic [N-1:0] b,
                       input string tag);
    item_t it;
    while (busy) @(negedge clk);
    dividend = a;
    divisor  = b;
    start    = 1'b1;
    it.dvd = a;
    it.dvs = b;
    it.expZ = (b == '0);
    it.expQ = (b == '0) ? MAXV : a / b;
    it.expR = (b == '0) ? a : a % b;
    it.doneCyc = cyc + 1 + N + 1;   // edge of acceptance, then N+1 more
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after accept", {63'd0, busy}, 64'd1);
  endtask

  // Monitor: pop and compare whenever done is seen.
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && done === 1'b1) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R3 done without request", 64'd1, 64'd0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(busy === 1'b0, "R3 busy low with done", {63'd0, busy}, 64'd0);
          chk(cyc == it.doneCyc, {"R3 latency ", it.tag}, cyc, it.doneCyc);
          chk(quotient === it.expQ, {"R4 quotient ", it.tag}, quotient, it.expQ);
          chk(remainder === it.expR, {"R4 remainder ", it.tag}, remainder, it.expR);
          chk(divByZero === it.expZ, {"R7 flag ", it.tag}, divByZero, it.expZ);
          if (!it.expZ) begin
            chk(({32'd0, quotient} * {32'd0, it.dvs} + {32'd0, remainder}) ==
                  {32'd0, it.dvd} && remainder < it.dvs,
                {"R4 identity ", it.tag}, {32'd0, remainder}, {32'd0, it.expR});
          end
          lastQ = quotient;
          lastR = remainder;
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk(busy === 1'b0, "R1 busy", {63'd0, busy}, 64'd0);
    chk(done === 1'b0, "R1 done", {63'd0, done}, 64'd0);
    chk(divByZero === 1'b0, "R1 flag", {63'd0, divByZero}, 64'd0);
    chk(quotient === '0 && remainder === '0, "R1 results",
        {quotient, remainder}, 64'd0);

    // R4 main function
    issue(32'd7, 32'd2, "7/2");
    issue(32'd100, 32'd7, "100/7");
    issue(32'hDEADBEEF, 32'h1234, "mixed");
    // R8 boundaries
    issue(32'h89ABCDEF, 32'd1, "div1");
    issue(32'd5, 32'd9, "small");
    issue(32'd0, 32'd5, "zero dividend");
    issue(MAXV, MAXV, "max/max");
    issue(MAXV, 32'd1, "max/1");
    issue(MAXV, 32'h80000001, "large rem");
    issue(32'hFFFFFFFE, 32'hFFFFFFFF, "rem top bit");
    // R7 zero divisor and flag clearing
    issue(32'h12345678, 32'd0, "dz");
    issue(32'd50, 32'd5, "after dz");
    issue(MAXV, 32'd0, "dz max");

    // R5 hold while idle
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(quotient === lastQ, "R5 quotient held", quotient, lastQ);
    chk(remainder === lastR, "R5 remainder held", remainder, lastR);

    // R6 start while busy ignored
    issue(32'd1000, 32'd3, "busy start");
    repeat (5) @(negedge clk);
    dividend = 32'd77;
    divisor  = 32'd0;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R6 still busy", {63'd0, busy}, 64'd1);

    // R9 back-to-back and random
    for (int i = 0; i < 40; i++) begin
      logic [N-1:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 3 == 0) b = b >> (i % 29);
      if (b == '0) b = 32'd3;
      issue(a, b, "R9 random");
    end

    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule